// File: doc/BRIEF.md
# Variable-Length Instruction Stream Decoder

This block accepts a stream of instruction bytes, one byte per handshake, and cuts it into whole instructions. The first byte of each instruction is an opcode. A signature lookup turns the opcode into zero, one or two operand descriptors, each with a kind and a byte width. The block then gathers the bytes that follow into operand values. Multi-byte values are assembled least significant byte first. An instruction is between one and nine bytes long.

When the last byte of an instruction arrives, the block presents one decoded record on a valid/ready output. The record holds the opcode, the operand count, both operand values with their kind tags, the total length in bytes and an illegal-opcode flag. It sits between a byte fetch queue and an execution stage. The input accepts a new byte in the same cycle that a waiting record is taken, so back-to-back one-byte instructions pass at one per cycle.

Top module: `vlen_decoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Opcodes 0x40, 0x45, 0x46 and 0x4D take no operands and produce a record with out_len 1 and out_count 0.
- R3: A register operand, and a register-pointer operand, is one byte holding the register number. It is returned zero-extended in the operand value.
- R4: A 32-bit immediate, and a 32-bit direct address, take four bytes, least significant first. For example, opcode 0x01 is register then 32-bit immediate, 6 bytes in total.
- R5: A 16-bit immediate takes two bytes and an 8-bit immediate takes one byte, least significant first. Opcode 0x0B is register-pointer then 16-bit immediate; 0x11 is register-pointer then 8-bit immediate; 0x1F is a single 8-bit immediate.
- R6: Opcode 0x44 takes two 32-bit immediates and is 9 bytes long.
- R7: An opcode above 0x4D sets out_illegal and is consumed as a one-byte instruction with out_count 0. Every opcode from 0x00 to 0x4D gives out_illegal 0.
- R8: No record is presented before the last byte of its instruction has been accepted. out_valid rises in the cycle after that byte's handshake, and missing bytes stall the output.
- R9: While out_valid is 1 and out_ready is 0, the record holds steady and in_ready is 0. Otherwise in_ready is 1.
- R10: An operand slot that the instruction does not use reads value 0 and kind 0.
- R11: The kind tag is 0 for register, 1 for register-pointer, 2 for immediate and 3 for direct address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block takes the offered byte |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | A decoded record is present |
| out_ready | input | 1 | The consumer takes the record |
| out_opcode | output | 8 | Opcode byte |
| out_count | output | 2 | Number of operands (0 to 2) |
| out_a | output | 32 | First operand value |
| out_a_kind | output | 2 | First operand kind tag |
| out_b | output | 32 | Second operand value |
| out_b_kind | output | 2 | Second operand kind tag |
| out_len | output | 4 | Instruction length in bytes |
| out_illegal | output | 1 | Opcode is outside the defined range |

## Verification
A record becomes visible exactly one clock after the handshake of its final byte, whatever the instruction's length. in_ready is a same-cycle function of the held record and out_ready. The bench drives each cycle's inputs after the falling edge. It checks in_ready a moment later in that same cycle, then advances its byte-level model as the rising edge will. The following falling edge compares out_valid and every record field against that model. Runs with byte gaps and output stalls confirm that the one-cycle latency and the hold behaviour do not depend on traffic.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
    parameter int OPND_BYTES = 4;
    localparam int OPND_W = 8 * OPND_BYTES;
    localparam int IDX_W  = $clog2(OPND_BYTES);
    localparam int NB_W   = $clog2(OPND_BYTES + 1);
    localparam int LEN_W  = $clog2(2 * OPND_BYTES + 2);

    typedef enum logic [1:0] {
        K_REG  = 2'd0,
        K_RPTR = 2'd1,
        K_IMM  = 2'd2,
        K_ADDR = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e           kind;
        logic [NB_W-1:0] nb;
    } opnd_t;

    typedef struct packed {
        opnd_t a;
        opnd_t b;
    } sig_t;
endpackage

// File: rtl/vlen_opsig.sv
module vlen_opsig
    import vlen_pkg::*;
#(
    parameter logic [7:0] LAST_OPCODE = 8'h4D
) (
    input  logic [7:0] op,
    output sig_t       sig,
    output logic       illegal
);
    localparam opnd_t O_NO = '{kind: K_REG,  nb: NB_W'(0)};
    localparam opnd_t O_R  = '{kind: K_REG,  nb: NB_W'(1)};
    localparam opnd_t O_P  = '{kind: K_RPTR, nb: NB_W'(1)};
    localparam opnd_t O_A  = '{kind: K_ADDR, nb: NB_W'(4)};
    localparam opnd_t O_I4 = '{kind: K_IMM,  nb: NB_W'(4)};
    localparam opnd_t O_I2 = '{kind: K_IMM,  nb: NB_W'(2)};
    localparam opnd_t O_I1 = '{kind: K_IMM,  nb: NB_W'(1)};

    logic [7:0] rel;
    opnd_t      iw;
    sig_t       s;

    always_comb begin
        s   = '{a: O_NO, b: O_NO};
        rel = op - 8'h08;
        iw  = (rel < 8'd6) ? O_I2 : O_I1;
        illegal = (op > LAST_OPCODE);
        case (op) inside
            [8'h00:8'h07]: begin
                case (op[2:0])
                    3'd0: s = '{a: O_R, b: O_R};
                    3'd1: s = '{a: O_R, b: O_I4};
                    3'd2: s = '{a: O_R, b: O_P};
                    3'd3: s = '{a: O_R, b: O_A};
                    3'd4: s = '{a: O_P, b: O_R};
                    3'd5: s = '{a: O_P, b: O_I4};
                    3'd6: s = '{a: O_A, b: O_R};
                    default: s = '{a: O_A, b: O_I4};
                endcase
            end
            [8'h08:8'h13]: begin
                case ((rel < 8'd6) ? rel : rel - 8'd6)
                    8'd0: s = '{a: O_R, b: O_P};
                    8'd1: s = '{a: O_R, b: O_A};
                    8'd2: s = '{a: O_P, b: O_R};
                    8'd3: s = '{a: O_P, b: iw};
                    8'd4: s = '{a: O_A, b: O_R};
                    default: s = '{a: O_A, b: iw};
                endcase
            end
            [8'h14:8'h1B]: s = '{a: O_R, b: (op[0] ? O_I4 : O_R)};
            8'h1C, 8'h1D: s = '{a: O_R, b: O_R};
            8'h1E:        s = '{a: O_R, b: O_NO};
            8'h1F:        s = '{a: O_I1, b: O_NO};
            [8'h20:8'h25]: begin
                if (!op[0])          s.a = O_R;
                else if (op == 8'h21) s.a = O_I4;
                else if (op == 8'h23) s.a = O_I2;
                else                 s.a = O_I1;
            end
            [8'h26:8'h28], 8'h2F: s = '{a: O_R, b: O_NO};
            [8'h29:8'h2E]: s = '{a: O_R, b: (op[0] ? O_R : O_I4)};
            8'h30, [8'h35:8'h3F]: s = '{a: O_R, b: O_I4};
            [8'h31:8'h34], [8'h41:8'h44]: begin
                case (op[1:0])
                    2'd1: s = '{a: O_R,  b: O_R};
                    2'd2: s = '{a: O_R,  b: O_I4};
                    2'd3: s = '{a: O_I4, b: O_R};
                    default: s = '{a: O_I4, b: O_I4};
                endcase
            end
            [8'h47:8'h4C]: begin
                case (op[2:0])
                    3'd7, 3'd1: s = '{a: O_R,  b: O_R};
                    3'd0, 3'd2: s = '{a: O_R,  b: O_I4};
                    3'd3:       s = '{a: O_I4, b: O_R};
                    default:    s = '{a: O_I4, b: O_I4};
                endcase
            end
            default: s = '{a: O_NO, b: O_NO};
        endcase
        sig = illegal ? '{a: O_NO, b: O_NO} : s;
    end
endmodule

// File: rtl/vlen_gather.sv
module vlen_gather
    import vlen_pkg::*;
#(
    parameter logic [7:0] LAST_OPCODE = 8'h4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_acc,
    input  logic [7:0]        in_byte,
    output logic              done,
    output logic [7:0]        done_opcode,
    output sig_t              done_sig,
    output logic [OPND_W-1:0] done_a,
    output logic [OPND_W-1:0] done_b,
    output logic              done_illegal
);
    typedef struct packed {
        logic              busy;
        logic              slot;
        logic [IDX_W-1:0]  idx;
        logic [7:0]        opcode;
        sig_t              sig;
        logic              illegal;
        logic [OPND_W-1:0] a;
        logic [OPND_W-1:0] b;
    } gst_t;

    gst_t              st_q, st_d;
    sig_t              new_sig;
    logic              new_ill;
    logic [NB_W-1:0]   cur_nb;
    logic [OPND_W-1:0] placed;

    vlen_opsig #(.LAST_OPCODE(LAST_OPCODE)) u_sig (
        .op      (in_byte),
        .sig     (new_sig),
        .illegal (new_ill)
    );

    always_comb begin
        st_d   = st_q;
        done   = 1'b0;
        cur_nb = st_q.slot ? st_q.sig.b.nb : st_q.sig.a.nb;
        placed = OPND_W'(in_byte) << {st_q.idx, 3'b000};
        if (in_acc) begin
            if (!st_q.busy) begin
                st_d.opcode  = in_byte;
                st_d.sig     = new_sig;
                st_d.illegal = new_ill;
                st_d.a       = '0;
                st_d.b       = '0;
                st_d.slot    = 1'b0;
                st_d.idx     = '0;
                if (new_sig.a.nb == '0) done = 1'b1;
                else                    st_d.busy = 1'b1;
            end else begin
                if (st_q.slot) st_d.b = st_q.b | placed;
                else           st_d.a = st_q.a | placed;
                if (NB_W'(st_q.idx) + NB_W'(1) == cur_nb) begin
                    if (!st_q.slot && st_q.sig.b.nb != '0) begin
                        st_d.slot = 1'b1;
                        st_d.idx  = '0;
                    end else begin
                        done      = 1'b1;
                        st_d.busy = 1'b0;
                    end
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_opcode  = st_d.opcode;
    assign done_sig     = st_d.sig;
    assign done_a       = st_d.a;
    assign done_b       = st_d.b;
    assign done_illegal = st_d.illegal;

    AST_IDX_WITHIN_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (NB_W'(st_q.idx) < cur_nb)); // R8
    AST_SECOND_SLOT_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.slot) |-> (st_q.sig.b.nb != '0)); // R8
    AST_BUSY_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !st_q.illegal); // R7
endmodule

// File: rtl/vlen_decoder.sv
module vlen_decoder
    import vlen_pkg::*;
#(
    parameter logic [7:0] LAST_OPCODE = 8'h4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_opcode,
    output logic [1:0]        out_count,
    output logic [OPND_W-1:0] out_a,
    output logic [1:0]        out_a_kind,
    output logic [OPND_W-1:0] out_b,
    output logic [1:0]        out_b_kind,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_illegal
);
    typedef struct packed {
        logic              valid;
        logic [7:0]        opcode;
        logic [1:0]        count;
        logic [OPND_W-1:0] a;
        logic [1:0]        ak;
        logic [OPND_W-1:0] b;
        logic [1:0]        bk;
        logic [LEN_W-1:0]  len;
        logic              illegal;
    } rec_t;

    rec_t              rec_q, rec_d;
    logic              acc;
    logic              g_done;
    logic [7:0]        g_opcode;
    sig_t              g_sig;
    logic [OPND_W-1:0] g_a;
    logic [OPND_W-1:0] g_b;
    logic              g_ill;

    assign in_ready = !rec_q.valid || out_ready;
    assign acc      = in_valid && in_ready;

    vlen_gather #(.LAST_OPCODE(LAST_OPCODE)) u_gather (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_acc       (acc),
        .in_byte      (in_byte),
        .done         (g_done),
        .done_opcode  (g_opcode),
        .done_sig     (g_sig),
        .done_a       (g_a),
        .done_b       (g_b),
        .done_illegal (g_ill)
    );

    always_comb begin
        rec_d = rec_q;
        if (rec_q.valid && out_ready) rec_d.valid = 1'b0;
        if (g_done) begin
            rec_d.valid   = 1'b1;
            rec_d.opcode  = g_opcode;
            rec_d.count   = 2'(g_sig.a.nb != '0) + 2'(g_sig.b.nb != '0);
            rec_d.a       = g_a;
            rec_d.b       = g_b;
            rec_d.ak      = (g_sig.a.nb != '0) ? g_sig.a.kind : K_REG;
            rec_d.bk      = (g_sig.b.nb != '0) ? g_sig.b.kind : K_REG;
            rec_d.len     = LEN_W'(1) + LEN_W'(g_sig.a.nb) + LEN_W'(g_sig.b.nb);
            rec_d.illegal = g_ill;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign out_valid   = rec_q.valid;
    assign out_opcode  = rec_q.opcode;
    assign out_count   = rec_q.count;
    assign out_a       = rec_q.a;
    assign out_a_kind  = rec_q.ak;
    assign out_b       = rec_q.b;
    assign out_b_kind  = rec_q.bk;
    assign out_len     = rec_q.len;
    assign out_illegal = rec_q.illegal;

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_opcode, out_count, out_a, out_b, out_len, out_illegal}))); // R9
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R9
    AST_ILLEGAL_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_len == LEN_W'(1) && out_count == 2'd0)); // R7
    AST_BARE_OPCODE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_count == 2'd0) |-> (out_len == LEN_W'(1))); // R2
    AST_UNUSED_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_count != 2'd2) |-> (out_b == '0 && out_b_kind == 2'd0)); // R10
    AST_RECORD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready)); // R8
endmodule

// File: tb/vlen_decoder_test.sv
`timescale 1ns/1ps
module vlen_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_opcode;
    logic [1:0]  out_count;
    logic [31:0] out_a;
    logic [1:0]  out_a_kind;
    logic [31:0] out_b;
    logic [1:0]  out_b_kind;
    logic [3:0]  out_len;
    logic        out_illegal;

    always #4 clk = ~clk;

    vlen_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode), .out_count(out_count),
        .out_a(out_a), .out_a_kind(out_a_kind), .out_b(out_b), .out_b_kind(out_b_kind),
        .out_len(out_len), .out_illegal(out_illegal)
    );

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit timed_out = 0;
    logic [7:0] stream[$];

    bit          m_busy = 0;
    int          m_need = 0;
    int          m_pos = 0;
    int          m_op = 0;
    logic [7:0]  m_buf[8];
    bit          e_valid = 0;
    int          e_op, e_cnt, e_ak, e_bk, e_len;
    logic [31:0] e_a, e_b;
    bit          e_ill;
    string       e_tag;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Kinds: 0 register, 1 register-pointer, 2 immediate, 3 direct address
    function automatic void bsig(input int op, output int k0, output int w0, output int k1, output int w1);
        string s;
        int iw;
        s = "";
        iw = 4;
        case (op)
            8'h00, 8'h14, 8'h16, 8'h18, 8'h1a, 8'h1c, 8'h1d, 8'h29, 8'h2b, 8'h2d,
            8'h31, 8'h41, 8'h47, 8'h49: s = "rr";
            8'h01, 8'h15, 8'h17, 8'h19, 8'h1b, 8'h2a, 8'h2c, 8'h2e, 8'h30, 8'h32,
            8'h35, 8'h36, 8'h37, 8'h38, 8'h39, 8'h3a, 8'h3b, 8'h3c, 8'h3d, 8'h3e, 8'h3f,
            8'h42, 8'h48, 8'h4a: s = "ri";
            8'h02, 8'h08, 8'h0e: s = "rp";
            8'h03, 8'h09, 8'h0f: s = "ra";
            8'h04, 8'h0a, 8'h10: s = "pr";
            8'h05: s = "pi";
            8'h0b: begin s = "pi"; iw = 2; end
            8'h11: begin s = "pi"; iw = 1; end
            8'h06, 8'h0c, 8'h12: s = "ar";
            8'h07: s = "ai";
            8'h0d: begin s = "ai"; iw = 2; end
            8'h13: begin s = "ai"; iw = 1; end
            8'h1e, 8'h20, 8'h22, 8'h24, 8'h26, 8'h27, 8'h28, 8'h2f: s = "r";
            8'h1f, 8'h25: begin s = "i"; iw = 1; end
            8'h21: s = "i";
            8'h23: begin s = "i"; iw = 2; end
            8'h33, 8'h43, 8'h4b: s = "ir";
            8'h34, 8'h44, 8'h4c: s = "ii";
            default: s = "";
        endcase
        k0 = 0; w0 = 0; k1 = 0; w1 = 0;
        for (int i = 0; i < s.len(); i++) begin
            int k, w;
            case (s[i])
                "r": begin k = 0; w = 1; end
                "p": begin k = 1; w = 1; end
                "i": begin k = 2; w = iw; end
                default: begin k = 3; w = 4; end
            endcase
            if (i == 0) begin k0 = k; w0 = w; end
            else begin k1 = k; w1 = w; end
        end
    endfunction

    task automatic emit();
        int k0, w0, k1, w1;
        bsig(m_op, k0, w0, k1, w1);
        e_valid = 1;
        e_op = m_op;
        e_ill = (m_op > 8'h4D);
        e_cnt = (w0 != 0) + (w1 != 0);
        e_len = 1 + w0 + w1;
        e_ak = (w0 != 0) ? k0 : 0;
        e_bk = (w1 != 0) ? k1 : 0;
        e_a = 0; e_b = 0;
        for (int i = 0; i < w0; i++) e_a = e_a | (32'(m_buf[i]) << (8 * i));
        for (int i = 0; i < w1; i++) e_b = e_b | (32'(m_buf[w0 + i]) << (8 * i));
        if (e_ill) e_tag = "R7";
        else if (e_cnt == 0) e_tag = "R2";
        else if (m_op == 8'h44) e_tag = "R6";
        else if (w0 == 4 || w1 == 4) e_tag = "R4";
        else if (k0 == 2 || k1 == 2) e_tag = "R5";
        else e_tag = "R3";
    endtask

    task automatic model_byte(logic [7:0] b);
        int k0, w0, k1, w1;
        if (!m_busy) begin
            m_op = b;
            bsig(m_op, k0, w0, k1, w1);
            m_need = w0 + w1;
            m_pos = 0;
            if (m_need == 0) emit();
            else m_busy = 1;
        end else begin
            m_buf[m_pos] = b;
            m_pos++;
            if (m_pos == m_need) begin
                m_busy = 0;
                emit();
            end
        end
    endtask

    task automatic one_cycle(int gap_pct, int rdy_pct);
        bit exp_rdy, acc;
        @(negedge clk);
        cycles++;
        chk(out_valid == e_valid, "R8", "out_valid", out_valid, e_valid);
        if (e_valid && out_valid) begin
            chk(out_opcode == e_op[7:0], e_tag, "opcode", out_opcode, e_op);
            chk(out_len == e_len[3:0], e_tag, "length", out_len, e_len);
            chk(out_count == e_cnt[1:0], e_tag, "count", out_count, e_cnt);
            chk(out_a == e_a, e_tag, "operand a", out_a, e_a);
            chk(out_b == e_b, (e_cnt == 2) ? e_tag : "R10", "operand b", out_b, e_b);
            chk(out_a_kind == e_ak[1:0], (e_cnt >= 1) ? "R11" : "R10", "kind a", out_a_kind, e_ak);
            chk(out_b_kind == e_bk[1:0], (e_cnt == 2) ? "R11" : "R10", "kind b", out_b_kind, e_bk);
            chk(out_illegal == e_ill, "R7", "illegal", out_illegal, e_ill);
        end
        in_valid = (stream.size() > 0) && (($urandom % 100) >= gap_pct);
        in_byte = (stream.size() > 0) ? stream[0] : 8'h00;
        out_ready = (($urandom % 100) < rdy_pct);
        #1;
        exp_rdy = !e_valid || out_ready;
        chk(in_ready == exp_rdy, "R9", "in_ready", in_ready, exp_rdy);
        acc = in_valid && exp_rdy;
        if (e_valid && out_ready) e_valid = 0;
        if (acc) begin
            model_byte(stream[0]);
            void'(stream.pop_front());
        end
    endtask

    task automatic drain(int gap_pct, int rdy_pct);
        while ((stream.size() > 0 || e_valid || m_busy) && !timed_out) begin
            one_cycle(gap_pct, rdy_pct);
            if (cycles > 150000) begin
                timed_out = 1;
                chk(0, "R8", "watchdog expired", cycles, 150000);
            end
        end
    endtask

    task automatic push(input logic [7:0] b[]);
        foreach (b[i]) stream.push_back(b[i]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

        // R2 bare opcodes, R4 0x01 and 0x06, R5 0x0B/0x11/0x1F, R6 0x44, R7 0x50/0xFF
        push('{8'h4D, 8'h40, 8'h45, 8'h46});
        push('{8'h01, 8'h03, 8'h78, 8'h56, 8'h34, 8'h12});
        push('{8'h0B, 8'h05, 8'hEF, 8'hBE});
        push('{8'h11, 8'h07, 8'hA5});
        push('{8'h1F, 8'h33});
        push('{8'h44, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88});
        push('{8'h06, 8'h00, 8'h10, 8'h00, 8'h00, 8'h02});
        push('{8'h50, 8'hFF, 8'h4E});
        push('{8'h30, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h00});
        push('{8'h33, 8'h01, 8'h00, 8'h00, 8'h00, 8'h09});
        push('{8'h2F, 8'h04, 8'h00, 8'h0A, 8'h0B});
        push('{8'h03, 8'h02, 8'hAA, 8'hBB, 8'hCC, 8'hDD});
        drain(0, 100);

        // R9: long stall with a record held, then release
        push('{8'h05, 8'h01, 8'h04, 8'h03, 8'h02, 8'h01, 8'h4D, 8'h0D, 8'h00, 8'h00, 8'h00, 8'h00, 8'h34, 8'h12});
        repeat (12) one_cycle(0, 0);
        drain(30, 50);

        // Random stream over all opcodes plus some undefined ones
        for (int n = 0; n < 400; n++) begin
            int op, k0, w0, k1, w1;
            op = $urandom % 96;
            stream.push_back(op[7:0]);
            bsig(op, k0, w0, k1, w1);
            for (int j = 0; j < w0 + w1; j++) stream.push_back(8'($urandom));
        end
        drain(25, 70);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule